// File: doc/BRIEF.md
# Power-Path Protection Sequencer

This block decides when the series pass switch of a supply input may conduct, and when the open-drain fault line may let go. Each clock cycle it may receive a digitised input-voltage code and a digitised junction-temperature code, qualified by a valid strobe. It compares each accepted sample with undervoltage, overvoltage and overtemperature limits. Each limit has its own hysteresis, so a condition that has been set clears only at a re-entry level on the safe side of its trip level.

Once every condition has been good without a break for a stabilisation delay, the switch closes. After a second delay the fault line is released. Overvoltage, overtemperature and undervoltage open the switch and pull the fault line low on the clock edge that takes the offending sample. Any such event during either delay restarts the whole sequence. An active-low enable puts the block into standby, where the switch is held open. The fault line does not look at the enable and runs the same combined delay either way. Both delays count ticks of a parameterised prescaler, so a 50 ms interval can be shortened for simulation.

The sample input is a one-way stream with a valid strobe and no ready. The block takes a sample on every cycle that valid is high and never applies back-pressure. A producer that cannot hold valid high simply sends fewer samples, and between samples the last decision on each condition holds.

Top module: `pwr_guard_seq`

## Requirements
- R1: While reset is high, and on the first clock after it, `gate_en_o` is 0 and `flt_n_o` is 0 (fault driven low).
- R2: With `en_n` low, `gate_en_o` rises only after every condition has been good for ON_TICKS prescaler ticks without a break. With the default clocking this is between (ON_TICKS-1)*TICK_DIV and ON_TICKS*TICK_DIV+2 clock cycles.
- R3: `flt_n_o` rises (released) a further REL_TICKS ticks after the switch-on delay ends, never earlier than `gate_en_o` when enabled.
- R4: A valid sample with code strictly above OV_TH makes `gate_en_o` 0 and `flt_n_o` 0 on the next clock edge. A code equal to OV_TH does not trip.
- R5: Once overvoltage is set, it clears only on a valid sample below OV_TH-OV_HYS, followed by both delays in full.
- R6: Undervoltage is set at reset. It clears only on a valid code strictly above UV_TH and is set again only by a code strictly below UV_TH-UV_HYS. While it is set, the switch is open and the fault line is low, and a trip takes effect on the next edge.
- R7: A valid temperature code at or above OT_TH trips on the next edge. It clears only once the code is at or below OT_TH-OT_HYS.
- R8: With `en_n` high, `gate_en_o` is 0 on the next edge. `flt_n_o` is unaffected and still runs its full sequence from fault to release.
- R9: When `en_n` returns low with all conditions good, `gate_en_o` closes only after a fresh ON_TICKS delay.
- R10: A fault during either delay window restarts both delays from zero once the conditions recover.
- R11: Codes presented with `s_valid` low are ignored, and the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Sample strobe; codes are taken when high |
| s_vin | input | VW | Input-voltage code |
| s_temp | input | TW | Junction-temperature code |
| en_n | input | 1 | Enable, active low; high means standby |
| gate_en_o | output | 1 | 1 closes the series pass switch |
| flt_n_o | output | 1 | 0 = fault line pulled low, 1 = released (high impedance) |

## Verification
The main function is tried with voltage codes on each side of both trip levels and inside each hysteresis band, and with temperature codes at the trip level, inside the band and at the re-entry level. These patterns separate a correct hysteresis from a single-threshold compare and from an off-by-one boundary. Delay timing is probed just before and just after each expected edge, which separates the two chained delays from a single merged delay. A short glitch placed inside a running delay shows whether the counters restart. Standby runs and runs with the strobe low show that the enable reaches only the switch and that unqualified codes change nothing.

// File: rtl/pg_pkg.sv
`timescale 1ns/1ps
package pg_pkg;
  typedef enum logic [1:0] {
    FS_LOCK    = 2'd0,
    FS_SETTLE  = 2'd1,
    FS_RELWAIT = 2'd2,
    FS_CLEAR   = 2'd3
  } flt_state_t;

  typedef struct packed {
    logic uv;
    logic ov;
    logic ot;
  } cond_t;
endpackage

// File: rtl/pg_tick.sv
`timescale 1ns/1ps
module pg_tick #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst || pre_q == LAST) pre_q <= '0;
        else                      pre_q <= pre_q + 1'b1;
      end
      assign tick_o = (pre_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/pg_window.sv
`timescale 1ns/1ps
module pg_window
  import pg_pkg::*;
#(
  parameter int VW     = 10,
  parameter int TW     = 8,
  parameter int UV_TH  = 325,
  parameter int UV_HYS = 5,
  parameter int OV_TH  = 575,
  parameter int OV_HYS = 9,
  parameter int OT_TH  = 145,
  parameter int OT_HYS = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  input  logic [VW-1:0] s_vin,
  input  logic [TW-1:0] s_temp,
  output cond_t         cond_o
);
  localparam logic [VW-1:0] UV_HI = VW'(UV_TH);
  localparam logic [VW-1:0] UV_LO = VW'(UV_TH - UV_HYS);
  localparam logic [VW-1:0] OV_HI = VW'(OV_TH);
  localparam logic [VW-1:0] OV_LO = VW'(OV_TH - OV_HYS);
  localparam logic [TW-1:0] OT_HI = TW'(OT_TH);
  localparam logic [TW-1:0] OT_LO = TW'(OT_TH - OT_HYS);

  cond_t held_q, nx;

  // each flag moves only across its own trip or re-entry level
  always_comb begin
    nx.uv = held_q.uv ? (s_vin <= UV_HI)  : (s_vin < UV_LO);
    nx.ov = held_q.ov ? (s_vin >= OV_LO)  : (s_vin > OV_HI);
    nx.ot = held_q.ot ? (s_temp > OT_LO)  : (s_temp >= OT_HI);
  end

  always_ff @(posedge clk) begin
    if (rst)          held_q <= '{uv: 1'b1, ov: 1'b0, ot: 1'b0};
    else if (s_valid) held_q <= nx;
  end

  // a fresh sample acts on the same edge that stores it
  assign cond_o = s_valid ? nx : held_q;
endmodule

// File: rtl/pg_delay.sv
`timescale 1ns/1ps
module pg_delay #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk) begin
    if (rst || clr)                 cnt_q <= '0;
    else if (tick && cnt_q != limit) cnt_q <= cnt_q + 1'b1;
  end
  assign done_o = (cnt_q == limit);
endmodule

// File: rtl/pwr_guard_seq.sv
`timescale 1ns/1ps
module pwr_guard_seq
  import pg_pkg::*;
#(
  parameter int VW         = 10,
  parameter int TW         = 8,
  parameter int UV_TH      = 325,
  parameter int UV_HYS     = 5,
  parameter int OV_TH      = 575,
  parameter int OV_HYS     = 9,
  parameter int OT_TH      = 145,
  parameter int OT_HYS     = 20,
  parameter int TICK_DIV   = 50000,
  parameter int ON_TICKS   = 50,
  parameter int REL_TICKS  = 50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  input  logic [VW-1:0] s_vin,
  input  logic [TW-1:0] s_temp,
  input  logic          en_n,
  output logic          gate_en_o,
  output logic          flt_n_o
);
  localparam int MAXT = (ON_TICKS > REL_TICKS) ? ON_TICKS : REL_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] ON_LIM  = CW'(ON_TICKS);
  localparam logic [CW-1:0] REL_LIM = CW'(REL_TICKS);

  logic       tick;
  cond_t      cond;
  logic       bad;
  flt_state_t st_q, st_nx;
  logic       f_clr, f_done, g_clr, g_done;
  logic [CW-1:0] f_lim;
  logic       gate_q;

  pg_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  pg_window #(
    .VW(VW), .TW(TW), .UV_TH(UV_TH), .UV_HYS(UV_HYS),
    .OV_TH(OV_TH), .OV_HYS(OV_HYS), .OT_TH(OT_TH), .OT_HYS(OT_HYS)
  ) u_win (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_vin(s_vin),
    .s_temp(s_temp), .cond_o(cond)
  );

  assign bad = cond.uv | cond.ov | cond.ot;

  // fault-line sequence: settle, then release; blind to the enable
  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      FS_LOCK:    if (!bad) st_nx = FS_SETTLE;
      FS_SETTLE:  if (bad) st_nx = FS_LOCK; else if (f_done) st_nx = FS_RELWAIT;
      FS_RELWAIT: if (bad) st_nx = FS_LOCK; else if (f_done) st_nx = FS_CLEAR;
      FS_CLEAR:   if (bad) st_nx = FS_LOCK;
      default:    st_nx = FS_LOCK;
    endcase
  end

  assign f_lim = (st_q == FS_SETTLE) ? ON_LIM : REL_LIM;
  assign f_clr = (st_q == FS_LOCK) || (st_nx != st_q);

  pg_delay #(.CW(CW)) u_fdly (
    .clk(clk), .rst(rst), .clr(f_clr), .tick(tick),
    .limit(f_lim), .done_o(f_done)
  );

  always_ff @(posedge clk) begin
    if (rst) st_q <= FS_LOCK;
    else     st_q <= st_nx;
  end

  // switch path: its own settle timer, restarted by a fault or by standby
  assign g_clr = bad | en_n;

  pg_delay #(.CW(CW)) u_gdly (
    .clk(clk), .rst(rst), .clr(g_clr), .tick(tick),
    .limit(ON_LIM), .done_o(g_done)
  );

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= !bad && !en_n && g_done;
  end

  assign gate_en_o = gate_q;
  assign flt_n_o   = (st_q == FS_CLEAR);
endmodule

// File: rtl/pg_guard_chk.sv
`timescale 1ns/1ps
module pg_guard_chk #(
  parameter int VW     = 10,
  parameter int TW     = 8,
  parameter int UV_TH  = 325,
  parameter int UV_HYS = 5,
  parameter int OV_TH  = 575,
  parameter int OT_TH  = 145
) (
  input logic          clk,
  input logic          rst,
  input logic          s_valid,
  input logic [VW-1:0] s_vin,
  input logic [TW-1:0] s_temp,
  input logic          en_n,
  input logic          gate_en_o,
  input logic          flt_n_o
);
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  always @(negedge clk) begin
    if (rst_seen == 1'b1)
      a_r1_reset_state: assert (!gate_en_o && !flt_n_o);
  end

  a_r4_ov_trip: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_vin > VW'(OV_TH)) |=> (!gate_en_o && !flt_n_o));

  a_r6_uv_trip: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_vin < VW'(UV_TH - UV_HYS)) |=> (!gate_en_o && !flt_n_o));

  a_r7_ot_trip: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_temp >= TW'(OT_TH)) |=> (!gate_en_o && !flt_n_o));

  a_r8_standby_open: assert property (@(posedge clk) disable iff (rst)
    en_n |=> !gate_en_o);

  a_r11_gate_holds: assert property (@(posedge clk) disable iff (rst)
    (gate_en_o && !s_valid && !en_n) |=> gate_en_o);

  a_r11_flt_holds: assert property (@(posedge clk) disable iff (rst)
    (flt_n_o && !s_valid) |=> flt_n_o);
endmodule

bind pwr_guard_seq pg_guard_chk #(
  .VW(VW), .TW(TW), .UV_TH(UV_TH), .UV_HYS(UV_HYS),
  .OV_TH(OV_TH), .OT_TH(OT_TH)
) u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_vin(s_vin),
  .s_temp(s_temp), .en_n(en_n), .gate_en_o(gate_en_o), .flt_n_o(flt_n_o)
);

// File: tb/sim_pwr_guard_seq.sv
`timescale 1ns/1ps
module sim_pwr_guard_seq;
  localparam int VW = 10;
  localparam int TW = 8;
  localparam int NV = 14;

  // rows: voltage code, temperature code, negedges to wait, gate, fault line
  localparam int ROW_V[NV] = '{300, 326, 322, 319, 324, 500, 576, 570, 565, 565, 565, 565, 575, 575};
  localparam int ROW_T[NV] = '{ 25,  25,  25,  25,  25,  25,  25,  25,  25, 145, 130, 125, 125, 144};
  localparam int ROW_W[NV] = '{100, 100, 100,   1, 100, 100,   1, 100, 100,   1, 100, 100,   1,   1};
  localparam bit ROW_G[NV] = '{  0,   1,   1,   0,   0,   1,   0,   0,   1,   0,   0,   1,   1,   1};
  localparam bit ROW_F[NV] = '{  0,   1,   1,   0,   0,   1,   0,   0,   1,   0,   0,   1,   1,   1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_valid = 1'b1;
  logic [VW-1:0] s_vin = '0;
  logic [TW-1:0] s_temp = 8'd25;
  logic en_n = 1'b0;
  logic gate_en_o, flt_n_o;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pwr_guard_seq #(
    .VW(VW), .TW(TW), .UV_TH(325), .UV_HYS(5), .OV_TH(575), .OV_HYS(9),
    .OT_TH(145), .OT_HYS(20), .TICK_DIV(4), .ON_TICKS(10), .REL_TICKS(10)
  ) u0 (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_vin(s_vin), .s_temp(s_temp),
    .en_n(en_n), .gate_en_o(gate_en_o), .flt_n_o(flt_n_o)
  );

  function automatic string row_tag(int i);
    case (i)
      0, 2, 3, 4:  return "R6";
      1, 5:        return "R2";
      6, 12:       return "R4";
      7, 8:        return "R5";
      default:     return "R7";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    s_vin = 10'd300;
    cyc(3);
    chk("R1", "gate in reset", gate_en_o, 1'b0);
    chk("R1", "fault in reset", flt_n_o, 1'b0);
    rst = 1'b0;
    cyc(1);
    chk("R1", "fault after reset", flt_n_o, 1'b0);

    // R2 / R3: both chained delays from a good input
    s_vin = 10'd400;
    cyc(30);
    chk("R2", "gate early", gate_en_o, 1'b0);
    cyc(15);
    chk("R2", "gate closed", gate_en_o, 1'b1);
    chk("R3", "fault still low after close", flt_n_o, 1'b0);
    cyc(25);
    chk("R3", "fault before release", flt_n_o, 1'b0);
    cyc(25);
    chk("R3", "fault released", flt_n_o, 1'b1);

    // R10: a glitch inside the delay restarts it
    s_vin = 10'd300;
    cyc(1);
    s_vin = 10'd400;
    cyc(20);
    s_vin = 10'd300;
    cyc(1);
    s_vin = 10'd400;
    cyc(30);
    chk("R10", "gate after restart", gate_en_o, 1'b0);
    cyc(15);
    chk("R10", "gate closes after full delay", gate_en_o, 1'b1);
    cyc(50);

    // threshold and hysteresis table
    for (int i = 0; i < NV; i++) begin
      s_vin  = VW'(ROW_V[i]);
      s_temp = TW'(ROW_T[i]);
      cyc(ROW_W[i]);
      chk(row_tag(i), $sformatf("row %0d gate", i), gate_en_o, ROW_G[i]);
      chk(row_tag(i), $sformatf("row %0d fault", i), flt_n_o, ROW_F[i]);
    end

    // R8 / R9: standby opens the switch, fault untouched
    s_vin = 10'd400;
    s_temp = 8'd25;
    cyc(1);
    en_n = 1'b1;
    cyc(1);
    chk("R8", "gate in standby", gate_en_o, 1'b0);
    chk("R8", "fault in standby", flt_n_o, 1'b1);
    cyc(60);
    en_n = 1'b0;
    cyc(30);
    chk("R9", "gate early after enable", gate_en_o, 1'b0);
    cyc(15);
    chk("R9", "gate after fresh delay", gate_en_o, 1'b1);

    // R8: fault sequence still runs while disabled
    en_n = 1'b1;
    s_vin = 10'd300;
    cyc(1);
    chk("R8", "fault on undervoltage in standby", flt_n_o, 1'b0);
    s_vin = 10'd400;
    cyc(69);
    chk("R8", "fault still low in standby", flt_n_o, 1'b0);
    cyc(31);
    chk("R8", "fault released in standby", flt_n_o, 1'b1);
    chk("R8", "gate open in standby", gate_en_o, 1'b0);
    en_n = 1'b0;
    cyc(45);
    chk("R9", "gate after enable", gate_en_o, 1'b1);

    // R11: unqualified codes are ignored
    s_valid = 1'b0;
    s_vin = 10'd700;
    cyc(5);
    chk("R11", "gate with strobe low", gate_en_o, 1'b1);
    chk("R11", "fault with strobe low", flt_n_o, 1'b1);
    s_valid = 1'b1;
    cyc(1);
    chk("R4", "gate on qualified overvoltage", gate_en_o, 1'b0);
    chk("R4", "fault on qualified overvoltage", flt_n_o, 1'b0);

    finish_run();
  end
endmodule